// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block holds one watchdog counter for each side of a two-sided bus bridge. A side's counter starts when a delayed completion on that side is ready to be collected. It stops when the initiator that issued the request comes back to retry. If the initiator does not come back in time, the counter expires. The block then tells the queue logic to throw the completion away and reports the event to software and to the system-error logic. The queue storage and the matching of retries to completions sit outside the block. This block only measures the waiting time.

Each side has its own length select: a long window of 2^15 clocks or a short window of 2^10 clocks. An expiry on either side sets one shared sticky status flag, which software clears by writing 1 to it. When the error enable is set, each expiry also produces a single-clock system-error request. All pins are plain control and status levels or pulses. No data flows through the block, so it has no valid/ready handshake.

Top module: `dtt_discard_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `discard`, `tmo_status` and `serr_req` are 0. A reset during a count cancels that count, and no discard follows.
- R2: With `short_sel[i]`=1 at the arm, `discard[i]` is high in the cycle that follows the 1024th rising edge after the edge that samples `arm[i]`.
- R3: With `short_sel[i]`=0 at the arm, that distance is 32768 edges.
- R4: The window length is captured when the counter is armed. A change of `short_sel[i]` during a count has no effect on that count.
- R5: A `retry[i]` pulse before expiry stops and clears the counter, and no discard follows.
- R6: `discard[i]` lasts exactly one cycle. After an expiry the counter stays idle and gives no further pulse until it is armed again.
- R7: An `arm[i]` during a count restarts it from zero. An `arm[i]` in the cycle that would have expired suppresses that discard and starts a fresh full window.
- R8: A `retry[i]` in the cycle that would have expired suppresses the discard.
- R9: Any expiry on either side sets `tmo_status` in the same cycle as the discard pulse. The flag then stays at 1.
- R10: `tmo_status` clears only on `stat_wr`=1 with `stat_wdata`=1. A write of 0 leaves it set. An expiry in the same cycle as a clearing write wins, and the flag stays 1.
- R11: `serr_req` is a one-cycle pulse, coincident with the discard pulse, when `serr_en` was 1 in the expiring cycle. When `serr_en` is 0, no pulse is produced.
- R12: The two sides are independent. Arming, retrying or expiring one side does not affect the other side's discard output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 2 | Per-side pulse: delayed completion ready, start the window (bit 0 primary, bit 1 secondary) |
| retry | input | 2 | Per-side pulse: matching retry seen, stop the window |
| short_sel | input | 2 | Per-side window select, 1 = 2^10 clocks, 0 = 2^15 clocks |
| serr_en | input | 1 | Allows an expiry to raise `serr_req` |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Status write data, 1 clears `tmo_status` |
| discard | output | 2 | Per-side one-cycle pulse: drop the completion |
| tmo_status | output | 1 | Sticky flag: some window expired |
| serr_req | output | 1 | One-cycle system-error request |

## Verification
The hardest cases to reach are the collisions on the exact expiry edge: a rearm, a retry or a clearing status write that lands in the very cycle the counter would expire. The bench reaches them by counting edges from the arming edge and driving the colliding input on the 1024th. It then checks that the pulse is missing or that it moves by a full window. A table of vectors covers these cases together with the plain timeouts, and directed tests handle the window latch, reset mid-count and two sides running at once.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } side_state_e;

  // terminal count for a window of 2**exp clocks
  function automatic int unsigned last_count(input int unsigned exp_bits);
    return (32'd1 << exp_bits) - 32'd1;
  endfunction

endpackage

// File: rtl/dtt_side_timer.sv
module dtt_side_timer
  import dtt_pkg::*;
#(
  parameter int unsigned LONG_EXP  = 15,
  parameter int unsigned SHORT_EXP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic retry_i,
  input  logic short_sel_i,
  output logic expire_o,
  output logic discard_o
);

  localparam int unsigned CW = LONG_EXP;
  localparam logic [CW-1:0] LONG_LAST  = CW'(last_count(LONG_EXP));
  localparam logic [CW-1:0] SHORT_LAST = CW'(last_count(SHORT_EXP));

  side_state_e   state_q;
  logic          short_q;
  logic [CW-1:0] cnt_q;
  logic          discard_q;
  logic [CW-1:0] last_val;
  logic          at_last;

  assign last_val = short_q ? SHORT_LAST : LONG_LAST;
  assign at_last  = (cnt_q == last_val);
  // arm and retry both override an expiry in the same cycle
  assign expire_o = (state_q == ST_COUNT) && at_last && !arm_i && !retry_i;
  assign discard_o = discard_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      short_q   <= 1'b0;
      cnt_q     <= '0;
      discard_q <= 1'b0;
    end else begin
      discard_q <= expire_o;
      if (arm_i) begin
        state_q <= ST_COUNT;
        cnt_q   <= '0;
        short_q <= short_sel_i;
      end else if (retry_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (state_q == ST_COUNT) begin
        if (at_last) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |=> !discard_o);  // R6
  AST_RETRY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_i && !arm_i) |=> !discard_o && state_q == ST_IDLE);  // R5
  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> !discard_o && cnt_q == '0 && state_q == ST_COUNT);  // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !arm_i) |=> !discard_o);  // R6

endmodule

// File: rtl/dtt_status.sv
module dtt_status #(
  parameter int unsigned NUM_SIDES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SIDES-1:0] expire_i,
  input  logic                 serr_en_i,
  input  logic                 wr_i,
  input  logic                 wdata_i,
  output logic                 status_o,
  output logic                 serr_o
);

  logic any_exp;
  logic clr_req;
  logic status_q;
  logic serr_q;

  assign any_exp  = |expire_i;
  assign clr_req  = wr_i && wdata_i;
  assign status_o = status_q;
  assign serr_o   = serr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      serr_q   <= 1'b0;
    end else begin
      serr_q <= any_exp && serr_en_i;
      if (any_exp)      status_q <= 1'b1;
      else if (clr_req) status_q <= 1'b0;
    end
  end

  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any_exp |=> status_o);  // R9
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && !clr_req) |=> status_o);  // R10
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_en_i |=> !serr_o);  // R11
  AST_SERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> status_o);  // R11

endmodule

// File: rtl/dtt_discard_timer.sv
module dtt_discard_timer #(
  parameter int unsigned NUM_SIDES = 2,
  parameter int unsigned LONG_EXP  = 15,
  parameter int unsigned SHORT_EXP = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SIDES-1:0] arm,
  input  logic [NUM_SIDES-1:0] retry,
  input  logic [NUM_SIDES-1:0] short_sel,
  input  logic                 serr_en,
  input  logic                 stat_wr,
  input  logic                 stat_wdata,
  output logic [NUM_SIDES-1:0] discard,
  output logic                 tmo_status,
  output logic                 serr_req
);

  logic [NUM_SIDES-1:0] expire;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dtt_side_timer #(
      .LONG_EXP  (LONG_EXP),
      .SHORT_EXP (SHORT_EXP)
    ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm[s]),
      .retry_i     (retry[s]),
      .short_sel_i (short_sel[s]),
      .expire_o    (expire[s]),
      .discard_o   (discard[s])
    );

    AST_DISCARD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      discard[s] |-> tmo_status);  // R9
  end

  dtt_status #(
    .NUM_SIDES (NUM_SIDES)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .serr_en_i (serr_en),
    .wr_i      (stat_wr),
    .wdata_i   (stat_wdata),
    .status_o  (tmo_status),
    .serr_o    (serr_req)
  );

  AST_SERR_WITH_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> (|discard));  // R11

endmodule

// File: tb/dtt_discard_timer_tb.sv
module dtt_discard_timer_tb;

  localparam int NS = 2;
  localparam int LS = 1024;
  localparam int LL = 32768;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [NS-1:0] arm, retry, short_sel, discard;
  logic          serr_en, stat_wr, stat_wdata, tmo_status, serr_req;

  dtt_discard_timer u_dut (
    .clk (clk), .rst_n (rst_n), .arm (arm), .retry (retry),
    .short_sel (short_sel), .serr_en (serr_en), .stat_wr (stat_wr),
    .stat_wdata (stat_wdata), .discard (discard),
    .tmo_status (tmo_status), .serr_req (serr_req)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // side, sel, en, retry_at, rearm_at, expected first discard (0 = none)
  typedef struct packed {
    logic        side;
    logic        sel;
    logic        en;
    logic [15:0] retry_at;
    logic [15:0] rearm_at;
    logic [16:0] exp_at;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 16'd0,    16'd0,    17'd1024},   // R2 R11
    '{1'b1, 1'b1, 1'b0, 16'd0,    16'd0,    17'd1024},   // R2 R11 R12
    '{1'b0, 1'b1, 1'b1, 16'd500,  16'd0,    17'd0},      // R5
    '{1'b1, 1'b1, 1'b1, 16'd0,    16'd300,  17'd1324},   // R7
    '{1'b0, 1'b1, 1'b1, 16'd0,    16'd1024, 17'd2048},   // R7 at expiry edge
    '{1'b1, 1'b1, 1'b1, 16'd1024, 16'd0,    17'd0},      // R8
    '{1'b0, 1'b0, 1'b1, 16'd0,    16'd0,    17'd32768},  // R3
    '{1'b1, 1'b1, 1'b0, 16'd1023, 16'd0,    17'd0}       // R5 last-but-one
  };

  task automatic clear_status();
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b1;
    @(negedge clk); stat_wr = 1'b0; stat_wdata = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int win, first, npulse, nserr, nother;
    win = v.sel ? 2*LS + 8 : LL + 8;
    first = 0; npulse = 0; nserr = 0; nother = 0;
    @(negedge clk);
    short_sel[v.side] = v.sel; serr_en = v.en; arm[v.side] = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      arm = '0; retry = '0;
      if (k == int'(v.retry_at)) retry[v.side] = 1'b1;
      if (k == int'(v.rearm_at)) arm[v.side] = 1'b1;
      @(posedge clk); #1;
      if (discard[v.side]) begin npulse++; if (first == 0) first = k; end
      if (serr_req) nserr++;
      if (discard[~v.side]) nother++;
    end
    @(negedge clk); arm = '0; retry = '0;
    chk(first == int'(v.exp_at), $sformatf("vec%0d R2 R3 R5 R7 R8 discard edge", idx),
        first, v.exp_at);
    chk(npulse == ((v.exp_at != 0) ? 1 : 0), $sformatf("vec%0d R6 pulse count", idx),
        npulse, (v.exp_at != 0) ? 1 : 0);
    chk(nserr == ((v.exp_at != 0 && v.en) ? 1 : 0), $sformatf("vec%0d R11 serr count", idx),
        nserr, (v.exp_at != 0 && v.en) ? 1 : 0);
    chk(nother == 0, $sformatf("vec%0d R12 other side", idx), nother, 0);
    chk(tmo_status == (v.exp_at != 0), $sformatf("vec%0d R9 status", idx),
        tmo_status, v.exp_at != 0);
    clear_status();
    #1;
    chk(tmo_status == 1'b0, $sformatf("vec%0d R10 cleared", idx), tmo_status, 0);
  endtask

  // arm side s; flip select at k==1 if flip; clearing write at k==clr_at
  task automatic arm_watch(input int s, input bit sel, input bit flip, input int clr_at,
                           input int win, output int first);
    first = 0;
    @(negedge clk); short_sel[s] = sel; arm[s] = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      arm = '0; stat_wr = 1'b0; stat_wdata = 1'b0;
      if (flip && k == 1) short_sel[s] = ~sel;
      if (k == clr_at) begin stat_wr = 1'b1; stat_wdata = 1'b1; end
      @(posedge clk); #1;
      if (discard[s] && first == 0) first = k;
    end
    @(negedge clk); stat_wr = 1'b0; stat_wdata = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first, cnt0, cnt1;
    rst_n = 1'b0; arm = '0; retry = '0; short_sel = '0;
    serr_en = 1'b0; stat_wr = 1'b0; stat_wdata = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk(discard == '0 && !tmo_status && !serr_req, "R1 outputs in reset",
        {discard, tmo_status, serr_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(discard == '0 && !tmo_status && !serr_req, "R1 outputs after reset",
        {discard, tmo_status, serr_req}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R4: select latched at arm
    arm_watch(0, 1'b1, 1'b1, 0, LS + 8, first);
    chk(first == LS, "R4 select latched at arm", first, LS);
    clear_status();

    // R10: write of 0 keeps flag, expiry beats same-cycle clear
    arm_watch(1, 1'b1, 1'b0, 0, LS + 4, first);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b0;
    @(negedge clk); stat_wr = 1'b0; #1;
    chk(tmo_status == 1'b1, "R10 write of zero ignored", tmo_status, 1);
    clear_status(); #1;
    arm_watch(0, 1'b1, 1'b0, LS, LS + 4, first);
    chk(first == LS, "R10 collision discard", first, LS);
    chk(tmo_status == 1'b1, "R10 set wins over clear", tmo_status, 1);
    clear_status();

    // R12: both sides armed, secondary retried
    @(negedge clk); short_sel = 2'b11; arm = 2'b11;
    @(posedge clk);
    cnt0 = 0; cnt1 = 0; first = 0;
    for (int k = 1; k <= LS + 8; k++) begin
      @(negedge clk); arm = '0; retry = '0;
      if (k == 10) retry[1] = 1'b1;
      @(posedge clk); #1;
      if (discard[0]) begin cnt0++; if (first == 0) first = k; end
      if (discard[1]) cnt1++;
    end
    chk(first == LS && cnt0 == 1, "R12 primary unaffected", first, LS);
    chk(cnt1 == 0, "R12 secondary retried", cnt1, 0);
    clear_status();

    // R1: reset mid-count cancels
    @(negedge clk); short_sel[0] = 1'b1; arm[0] = 1'b1;
    @(negedge clk); arm = '0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cnt0 = 0;
    for (int k = 0; k < LS + 50; k++) begin
      @(posedge clk); #1;
      if (discard != '0 || tmo_status) cnt0++;
    end
    chk(cnt0 == 0, "R1 reset cancels count", cnt0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule